// File: doc/BRIEF.md
# Write Completion Status Reporter

This block chooses the byte a host reads back from a byte-wide nonvolatile memory. While an internal program or erase runs, it replaces the array data with status. Software polls it to learn when the operation has finished.

The write controller pulses `start` when the strobe that launches the internal cycle ends. In that cycle the block captures the last loaded byte and the operation type. While `busy` stays high, each read returns a polling byte:

- bit 7 is the inverse of the captured byte's top bit. This inversion applies to program operations only.
- bit 6 flips on every read.
- bits 5..0 read zero.

When `busy` falls, a settling window of `SETTLE_CYC` clocks follows. In this window the two top bits already carry array data. The low six bits are scrambled in a fixed, alternating way, so two back-to-back reads never agree until the byte is really valid. After the window, reads pass the array data straight through.

Top module: `wr_status_mux`

## Requirements
- R1: After reset `rd_data` is 8'h00 and the block is idle (reads pass through).
- R2: When idle, a read strobe sampled at a clock edge loads `arr_data` into `rd_data` at that edge.
- R3: `rd_data` changes only at an edge where `rd_strobe` is high. Changing `arr_data` without a strobe leaves it unchanged.
- R4: During a program operation (`erase_op` was 0 at `start`), bit 7 of every read is the inverse of bit 7 of `last_data` as captured at `start`.
- R5: The first read after `start` has bit 6 = 1. Each further read while busy inverts bit 6.
- R6: During an erase operation (`erase_op` was 1 at `start`), bit 7 reads 0 while bit 6 still toggles as in R5.
- R7: While busy, bits 5..0 of every read are 0.
- R8: For `SETTLE_CYC` clocks after the edge where the block sees `busy` low, reads return `arr_data[7:6]` unchanged and `arr_data[5:0]` XOR a mask. The mask is 6'h3F on the first read of the window and alternates with 6'h00 on each later read.
- R9: After the settling window, reads pass `arr_data` through unchanged. A `start` pulse in any phase restarts status reporting, with bit 6 again reading 1 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse at the end of the strobe that launches the internal operation |
| busy | input | 1 | High while the internal operation runs |
| erase_op | input | 1 | Operation type at `start`: 1 = chip erase, 0 = program |
| last_data | input | 8 | Last byte loaded, captured at `start` |
| rd_strobe | input | 1 | Read request, one per read cycle |
| arr_data | input | 8 | Array read data |
| rd_data | output | 8 | Registered read data returned to the host |

## Verification
The most visible fault is a wrong phase register, since every bit of every read depends on it. A stuck busy phase shows on the very next strobe: it returns 0 in the low six bits instead of array data. An early exit from settling shows as two equal consecutive reads before the window has elapsed. A toggle flop that fails to preset or to flip appears within the first two reads after `start`. A wrongly captured top bit is caught by a sweep over all 256 values of `last_data` on the first poll.

// File: rtl/wr_status_mux.sv
module wr_status_mux #(
  parameter int SETTLE_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       busy,
  input  logic       erase_op,
  input  logic [7:0] last_data,
  input  logic       rd_strobe,
  input  logic [7:0] arr_data,
  output logic [7:0] rd_data
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_BUSY, PH_SETTLE} ph_t;

  ph_t           ph;
  logic [CW-1:0] cnt;
  logic          tgl, sfl, top_q, ers_q;
  logic [7:0]    nxt_rd;

  always_comb begin
    case (ph)
      PH_BUSY:   nxt_rd = {ers_q ? 1'b0 : ~top_q, tgl, 6'b0};
      PH_SETTLE: nxt_rd = {arr_data[7:6], arr_data[5:0] ^ {6{sfl}}};
      default:   nxt_rd = arr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      tgl     <= 1'b0;
      sfl     <= 1'b0;
      top_q   <= 1'b0;
      ers_q   <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      if (rd_strobe) rd_data <= nxt_rd;
      if (start) begin
        ph    <= PH_BUSY;
        tgl   <= 1'b1;
        top_q <= last_data[7];
        ers_q <= erase_op;
      end else begin
        case (ph)
          PH_BUSY: begin
            if (rd_strobe) tgl <= ~tgl;
            if (!busy) begin
              ph  <= PH_SETTLE;
              cnt <= CW'(SETTLE_CYC - 1);
              sfl <= 1'b1;
            end
          end
          PH_SETTLE: begin
            if (rd_strobe) sfl <= ~sfl;
            if (cnt == '0) ph <= PH_IDLE;
            else cnt <= cnt - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && ph == PH_IDLE) |=> rd_data == $past(arr_data));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data));

  p_poll_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && ph == PH_BUSY && !ers_q) |=> rd_data[7] != top_q);

  p_first_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ph == PH_BUSY && tgl));

  p_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && ph == PH_BUSY && !start) |=> tgl != $past(tgl));

  p_erase_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && ph == PH_BUSY && ers_q) |=> rd_data[7] == 1'b0);

  p_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && ph == PH_BUSY) |=> rd_data[5:0] == 6'b0);

  p_settle_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SETTLE && cnt == '0 && !start) |=> ph == PH_IDLE);
endmodule

// File: tb/wr_status_mux_test.sv
module wr_status_mux_test;
  localparam int CLK_P = 10;
  localparam int SC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, busy = 1'b0, erase_op = 1'b0, rd_strobe = 1'b0;
  logic [7:0] last_data = 8'h00, arr_data = 8'h00;
  logic [7:0] rd_data;
  int         total = 0, bad = 0;
  logic       done = 1'b0;

  wr_status_mux #(.SETTLE_CYC(SC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .erase_op(erase_op),
    .last_data(last_data), .rd_strobe(rd_strobe), .arr_data(arr_data), .rd_data(rd_data)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic rd(output logic [7:0] q);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    q = rd_data;
  endtask

  task automatic launch(input logic [7:0] v, input logic er);
    last_data = v; erase_op = er; start = 1'b1; busy = 1'b1;
    @(negedge clk);
    start = 1'b0; last_data = ~v; erase_op = ~er;
  endtask

  task automatic finish_op();
    busy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] q, a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset value", rd_data, 8'h00);

    for (int i = 0; i < 256; i++) begin
      arr_data = 8'(i);
      rd(q);
      chk("R2 idle pass", q, 8'(i));
      arr_data = 8'(i) ^ 8'hFF;
      @(negedge clk);
      chk("R3 hold without strobe", rd_data, 8'(i));
    end

    for (int v = 0; v < 256; v++) begin
      a = 8'(v) ^ 8'h5A;
      arr_data = a;
      launch(8'(v), 1'b0);
      rd(q);
      chk("R4 inverted top bit", {7'b0, q[7]}, {7'b0, ~v[7]});
      chk("R5 first toggle is 1", {7'b0, q[6]}, 8'h01);
      chk("R7 low bits zero", {2'b0, q[5:0]}, 8'h00);
      rd(q);
      chk("R5 second toggle is 0", {7'b0, q[6]}, 8'h00);
      chk("R4 inverted top bit again", {7'b0, q[7]}, {7'b0, ~v[7]});
      rd(q);
      chk("R5 third toggle is 1", {7'b0, q[6]}, 8'h01);
      finish_op();
      rd(q);
      chk("R8 first settle read", q, {a[7:6], ~a[5:0]});
      rd(q);
      chk("R8 second settle read", q, a);
      repeat (SC) @(negedge clk);
      rd(q);
      chk("R9 pass after settle", q, a);
    end

    for (int v = 0; v < 4; v++) begin
      a = 8'(v * 67 + 128);
      arr_data = a;
      launch(8'(v * 64), 1'b1);
      rd(q);
      chk("R6 erase first read", q, 8'h40);
      rd(q);
      chk("R6 erase second read", q, 8'h00);
      finish_op();
      repeat (SC + 2) @(negedge clk);
      rd(q);
      chk("R6 erase then pass", q, a);
    end

    arr_data = 8'h3C;
    launch(8'h00, 1'b0);
    rd(q);
    rd(q);
    chk("R5 toggle before restart", q, 8'h80);
    finish_op();
    launch(8'h80, 1'b0);
    rd(q);
    chk("R9 restart during settle", q, 8'h40);
    finish_op();
    repeat (SC + 2) @(negedge clk);
    rd(q);
    chk("R9 pass after restart", q, 8'h3C);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule